// File: doc/BRIEF.md
# Linked-Ring Transmit DMA Channel

This block is one transmit DMA channel. It follows a circular chain of 16-byte descriptors in memory. For each descriptor it reads three words through a memory read port: a control word, a link to the next descriptor and a buffer pointer. It then fetches the payload one 32-bit word at a time and hands it to a switch port as a byte stream with a valid/ready handshake. When the last byte has gone, it marks the descriptor complete through a memory write port and moves to the linked descriptor.

Software has three registers: a start address, a command and a poll interval. A descriptor whose control word carries the hold flag stops the channel. The channel then reads that control word again each time the poll timer expires. A resume command makes it read the word again at once, and an off command returns it to idle.

Top module: `txdesc_dma`

## Requirements
- R1: During reset and after it ends, rd_req, wr_req, tx_valid, irq_cpt and irq_eop are all low until a start command arrives.
- R2: Register writes use reg_addr 0 for the start address (bits 3:0 ignored), reg_addr 1 for commands and reg_addr 2 for the poll interval (bits 7:0). Command values in reg_wdata[1:0] are 1 = start, 2 = resume and 3 = off. A start command issued in idle fetches the control word at the start address.
- R3: Each descriptor has four words: control at +0, next link at +4, buffer pointer at +8 and status at +12. Control bits 21:0 give the byte count. The payload is read from the word-aligned buffer and sent lowest byte first. tx_sop marks the first byte when control bit 29 is set, and tx_eop marks the last byte when control bit 30 is set.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_eop hold their values into the next cycle.
- R5: Once the last byte has been accepted, the block writes 32'h8000_0000 (completion flag in bit 31) to descriptor +12. It then fetches the control word at the next link, ignoring the link's bits 3:0.
- R6: In the cycle the completion write is accepted, irq_cpt pulses if control bit 28 is set and irq_eop pulses if control bit 27 is set.
- R7: A control word with bit 31 (hold) set causes no payload read, no byte and no write-back, and the channel parks on that descriptor.
- R8: While parked, the block reads the same control word again interval x 1024 clocks after the hold word was accepted. An interval of 0 gives one clock.
- R9: A resume command while parked raises the control-word read request in the cycle after the command is sampled.
- R10: A descriptor with a byte count of zero sends no bytes but is still written back as complete.
- R11: An off command lets any beat already under way finish, then returns to idle. After that there are no further bytes, reads or descriptor writes. The interrupted descriptor's status is left untouched.
- R12: rd_req and rd_addr hold until rd_valid, and wr_req and wr_addr hold until wr_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_valid | input | 1 | Read data valid, completes the request |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write accepted |
| tx_valid | output | 1 | Payload byte valid |
| tx_ready | input | 1 | Switch port accepts byte |
| tx_data | output | 8 | Payload byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Last byte of packet |
| irq_cpt | output | 1 | Completion interrupt pulse |
| irq_eop | output | 1 | End-of-packet interrupt pulse |

## Verification
The bench's memory answers each request two cycles after it first sees it. A held control word is therefore re-requested exactly interval x 1024 + 2 cycles after its previous request began, and the bench compares that gap to the exact value. After a resume command, the new request must appear in the cycle right after the edge that sampled the command. Bytes and write-backs are compared in the same cycle the handshake completes, and the interrupt pulses are sampled in that same cycle. All samples are taken half a clock away from the active edge, once the bench's inputs have settled.

// File: rtl/txdesc_dma.sv
`timescale 1ns/1ps
module txdesc_dma #(
  parameter int ADDR_W    = 32,
  parameter int IVAL_W    = 8,
  parameter int POLL_UNIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ack,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              irq_cpt,
  output logic              irq_eop
);
  localparam int CNT_W = 22;
  localparam int TW    = IVAL_W + $clog2(POLL_UNIT) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CTL, S_PARK, S_NXT, S_BUF, S_LOAD, S_SEND, S_WB} st_t;

  st_t                st;
  logic [ADDR_W-5:0]  fda_blk, cur_blk, nxt_blk;
  logic [ADDR_W-3:0]  bufw;
  logic [IVAL_W-1:0]  ival;
  logic [TW-1:0]      timer;
  logic [CNT_W-1:0]   rem;
  logic [31:0]        word;
  logic [1:0]         idx;
  logic               first, stop_q, f_sop, f_eop, f_icpt, f_ieop;

  wire cmd_we   = reg_we && reg_addr == 2'd1;
  wire cmd_init = cmd_we && reg_wdata[1:0] == 2'd1;
  wire cmd_res  = cmd_we && reg_wdata[1:0] == 2'd2;
  wire cmd_off  = cmd_we && reg_wdata[1:0] == 2'd3;
  wire halt     = stop_q || cmd_off;

  wire [TW-1:0] lim       = TW'(ival) * TW'(POLL_UNIT);
  wire          park_done = (lim == '0) || (timer == lim - 1'b1);

  assign rd_req   = st == S_CTL || st == S_NXT || st == S_BUF || st == S_LOAD;
  assign wr_req   = st == S_WB;
  assign wr_addr  = {cur_blk, 4'hC};
  assign wr_data  = 32'h8000_0000;
  assign tx_valid = st == S_SEND;
  assign tx_data  = word[{idx, 3'b000} +: 8];
  assign tx_sop   = tx_valid && first && f_sop;
  assign tx_eop   = tx_valid && rem == CNT_W'(1) && f_eop;
  assign irq_cpt  = wr_req && wr_ack && f_icpt;
  assign irq_eop  = wr_req && wr_ack && f_ieop;

  always_comb begin
    case (st)
      S_NXT:   rd_addr = {cur_blk, 4'h4};
      S_BUF:   rd_addr = {cur_blk, 4'h8};
      S_LOAD:  rd_addr = {bufw, 2'b00};
      default: rd_addr = {cur_blk, 4'h0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fda_blk <= '0; cur_blk <= '0; nxt_blk <= '0; bufw <= '0;
      ival <= '0; timer <= '0; rem <= '0; word <= '0; idx <= '0;
      first <= 1'b0; stop_q <= 1'b0;
      f_sop <= 1'b0; f_eop <= 1'b0; f_icpt <= 1'b0; f_ieop <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 2'd0) fda_blk <= reg_wdata[ADDR_W-1:4];
      if (reg_we && reg_addr == 2'd2) ival <= reg_wdata[IVAL_W-1:0];
      if (st == S_IDLE) stop_q <= 1'b0;
      else if (cmd_off) stop_q <= 1'b1;

      case (st)
        S_IDLE: if (cmd_init) begin cur_blk <= fda_blk; st <= S_CTL; end
        S_CTL: if (rd_valid) begin
          if (halt) st <= S_IDLE;
          else begin
            f_eop <= rd_data[30]; f_sop <= rd_data[29];
            f_icpt <= rd_data[28]; f_ieop <= rd_data[27];
            rem <= rd_data[CNT_W-1:0];
            timer <= '0;
            st <= rd_data[31] ? S_PARK : S_NXT;
          end
        end
        S_PARK: begin
          if (halt) st <= S_IDLE;
          else if (cmd_res || park_done) st <= S_CTL;
          else timer <= timer + 1'b1;
        end
        S_NXT: if (rd_valid) begin
          nxt_blk <= rd_data[ADDR_W-1:4];
          st <= halt ? S_IDLE : S_BUF;
        end
        S_BUF: if (rd_valid) begin
          bufw <= rd_data[ADDR_W-1:2];
          first <= 1'b1;
          if (halt) st <= S_IDLE;
          else st <= (rem == '0) ? S_WB : S_LOAD;
        end
        S_LOAD: if (rd_valid) begin
          word <= rd_data; idx <= 2'd0; bufw <= bufw + 1'b1;
          st <= halt ? S_IDLE : S_SEND;
        end
        S_SEND: if (tx_ready) begin
          first <= 1'b0; rem <= rem - 1'b1; idx <= idx + 2'd1;
          if (halt) st <= S_IDLE;
          else if (rem == CNT_W'(1)) st <= S_WB;
          else if (idx == 2'd3) st <= S_LOAD;
        end
        S_WB: if (wr_ack) begin
          cur_blk <= nxt_blk;
          st <= halt ? S_IDLE : S_CTL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eop));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr));
  // R7
  hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CTL && rd_valid && rd_data[31] |=> !rd_req && !tx_valid && !wr_req);
  // R3
  eop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eop |=> !tx_valid);
  // R11
  off_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q || cmd_off) && !wr_req |=> !wr_req);
endmodule

// File: tb/txdesc_dma_bench.sv
`timescale 1ns/1ps
module txdesc_dma_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic rd_req, wr_req, tx_valid, tx_sop, tx_eop, irq_cpt, irq_eop;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [7:0] tx_data;
  logic rd_valid = 1'b0, wr_ack = 1'b0, tx_ready = 1'b0;
  logic [31:0] rd_data = '0;

  txdesc_dma u_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .irq_cpt(irq_cpt), .irq_eop(irq_eop));

  typedef struct packed { logic [7:0] d; logic s; logic e; } beat_t;
  beat_t bq[$];
  logic [31:0] wbq_a[$], wbq_c[$];
  logic [31:0] mem [0:2047];

  int cyc = 0, n_chk = 0, n_bad = 0;
  int rlat = 0, wlat = 0, beats = 0, wr_cyc = 0;
  int watch_addr = -1, watch_hits = 0, watch_last = 0, watch_prev = 0;
  bit rdy_hi = 0, quiet_mon = 0, quiet_bad = 0;
  bit prev_req = 0, prev_vld = 0, hold_pend = 0;
  logic [7:0] hold_data;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed * 29 + k * 13 + 5);
  endfunction

  task automatic prog(int d, logic [31:0] ctl, logic [31:0] nx, logic [31:0] bf);
    mem[d/4] = ctl; mem[d/4+1] = nx; mem[d/4+2] = bf; mem[d/4+3] = '0;
  endtask

  task automatic expect_pkt(int d, logic [31:0] ctl, int bf, int n, int seed);
    for (int k = 0; k < n; k++) begin
      mem[bf/4 + k/4][8*(k%4) +: 8] = pat(seed, k);
      bq.push_back('{d: pat(seed, k), s: (k == 0) && ctl[29], e: (k == n-1) && ctl[30]});
    end
    wbq_a.push_back(32'(d + 12)); wbq_c.push_back(ctl);
  endtask

  task automatic regw(logic [1:0] a, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v; wr_cyc = cyc;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_hits(int n, int tmo, string req);
    for (int i = 0; i < tmo && watch_hits < n; i++) @(negedge clk);
    chk(watch_hits >= n, req, "control read seen", watch_hits, n);
  endtask

  task automatic wait_drain(int tmo, string req);
    for (int i = 0; i < tmo && (bq.size() != 0 || wbq_a.size() != 0); i++) @(negedge clk);
    chk(bq.size() == 0 && wbq_a.size() == 0, req, "pending items", bq.size() + wbq_a.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rd_valid) rd_valid = 1'b0;
    else if (rd_req) begin
      rlat++;
      if (rlat == 2) begin rlat = 0; rd_valid = 1'b1; rd_data = mem[rd_addr[12:2]]; end
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      wlat++;
      if (wlat == 2) begin wlat = 0; wr_ack = 1'b1; end
    end
    tx_ready = rdy_hi || (cyc % 3 != 1);
    #1;
    if (rst_n) begin
      if (hold_pend)
        chk(tx_valid && tx_data == hold_data, "R4", "stalled byte", tx_data, hold_data);
      hold_pend = tx_valid && !tx_ready;
      hold_data = tx_data;
      if (tx_valid && tx_ready) begin
        beats++;
        if (bq.size() == 0) chk(0, "R7 R11", "unexpected byte", tx_data, 0);
        else begin
          beat_t e;
          e = bq.pop_front();
          chk(tx_data == e.d, "R3", "byte", tx_data, e.d);
          chk(tx_sop == e.s && tx_eop == e.e, "R3", "sop/eop", {tx_sop, tx_eop}, {e.s, e.e});
        end
      end
      if (wr_req && wr_ack) begin
        if (wbq_a.size() == 0) chk(0, "R7 R11", "unexpected write", wr_addr, 0);
        else begin
          logic [31:0] a, c;
          a = wbq_a.pop_front(); c = wbq_c.pop_front();
          chk(wr_addr == a, "R5", "write-back addr", wr_addr, a);
          chk(wr_data == 32'h8000_0000, "R5", "write-back data", wr_data, 32'h8000_0000);
          chk(irq_cpt == c[28] && irq_eop == c[27], "R6", "irq pulses",
              {irq_cpt, irq_eop}, {c[28], c[27]});
        end
        mem[wr_addr[12:2]] = wr_data;
      end else if (irq_cpt || irq_eop)
        chk(0, "R6", "irq without write-back", {irq_cpt, irq_eop}, 0);
      if (rd_req && (!prev_req || prev_vld) && int'(rd_addr) == watch_addr) begin
        watch_prev = watch_last; watch_last = cyc; watch_hits++;
      end
      if (quiet_mon && (rd_req || wr_req || tx_valid)) quiet_bad = 1;
    end
    prev_req = rd_req; prev_vld = rd_valid;
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog: actual %0d expected below 100000", cyc);
    summary();
    $finish;
  end

  initial begin
    int b0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk(!rd_req && !wr_req && !tx_valid && !irq_cpt && !irq_eop, "R1", "outputs in reset",
        {rd_req, wr_req, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd_req && !wr_req && !tx_valid, "R1", "outputs after reset", {rd_req, wr_req, tx_valid}, 0);

    prog('h100, 32'h7000_0004, 32'h117, 32'h1000);
    expect_pkt('h100, 32'h7000_0004, 'h1000, 4, 1);
    prog('h110, 32'h6800_0007, 32'h120, 32'h1100);
    expect_pkt('h110, 32'h6800_0007, 'h1100, 7, 2);
    prog('h120, 32'hE000_0005, 32'h100, 32'h1200);
    watch_addr = 'h120; watch_hits = 0;
    regw(2'd2, 32'd7);
    regw(2'd0, 32'h10B);
    regw(2'd1, 32'd1);
    wait_hits(1, 400, "R2");
    repeat (10) @(negedge clk);
    chk(bq.size() == 0 && wbq_a.size() == 0, "R7", "ring drained before held desc",
        bq.size(), 0);
    mem['h100/4] = 32'h8000_0000;
    mem['h120/4] = 32'h6000_0005;
    expect_pkt('h120, 32'h6000_0005, 'h1200, 5, 3);
    wait_hits(2, 9000, "R8");
    chk(watch_last - watch_prev == 7 * 1024 + 2, "R8", "poll gap", watch_last - watch_prev,
        7 * 1024 + 2);

    watch_addr = 'h100; watch_hits = 0;
    wait_hits(1, 400, "R7");
    repeat (10) @(negedge clk);
    chk(bq.size() == 0 && wbq_a.size() == 0, "R7", "parked at held desc", bq.size(), 0);
    mem['h110/4] = 32'h8000_0000;
    prog('h100, 32'h5000_0000, 32'h110, 32'h1000);
    wbq_a.push_back(32'h10C); wbq_c.push_back(32'h5000_0000);
    b0 = beats;
    regw(2'd1, 32'd2);
    repeat (3) @(negedge clk);
    chk(watch_hits == 2 && watch_last == wr_cyc + 1, "R9", "resume re-read cycle",
        watch_last, wr_cyc + 1);
    watch_addr = 'h110; watch_hits = 0;
    wait_drain(200, "R10");
    chk(mem['h10C/4] == 32'h8000_0000, "R10", "zero-length status", mem['h10C/4], 32'h8000_0000);
    chk(beats == b0, "R10", "bytes from zero-length", beats - b0, 0);

    wait_hits(1, 400, "R7");
    repeat (10) @(negedge clk);
    prog('h110, 32'h6000_0028, 32'h120, 32'h1300);
    for (int k = 0; k < 40; k++) begin
      mem['h1300/4 + k/4][8*(k%4) +: 8] = pat(4, k);
      bq.push_back('{d: pat(4, k), s: k == 0, e: k == 39});
    end
    rdy_hi = 1;
    b0 = beats;
    regw(2'd1, 32'd2);
    for (int i = 0; i < 400 && beats < b0 + 10; i++) @(negedge clk);
    regw(2'd1, 32'd3);
    bq.delete();
    quiet_mon = 1; quiet_bad = 0;
    repeat (100) @(negedge clk);
    quiet_mon = 0;
    chk(!quiet_bad, "R11", "activity after off", quiet_bad, 0);
    chk(mem['h11C/4] == 0, "R11", "interrupted status", mem['h11C/4], 0);
    chk(beats - b0 < 40, "R11", "bytes before stop", beats - b0, 39);
    rdy_hi = 0;

    mem['h100/4] = 32'h8000_0000;
    prog('h120, 32'h7800_0003, 32'h107, 32'h1400);
    expect_pkt('h120, 32'h7800_0003, 'h1400, 3, 5);
    regw(2'd0, 32'h12F);
    regw(2'd1, 32'd1);
    wait_drain(400, "R2");
    chk(mem['h12C/4] == 32'h8000_0000, "R5", "restart status", mem['h12C/4], 32'h8000_0000);
    repeat (20) @(negedge clk);
    summary();
    $finish;
  end
endmodule